// File: doc/BRIEF.md
# SDRAM Column Burst Engine with Clock Suspend

This block is the device side of a synchronous DRAM column path. It accepts column READ and WRITE commands that carry a bank and a column address, then runs a fixed-length burst over an aligned group of columns. Writes take one data word per internal cycle into a small on-chip array. Reads return one word per internal cycle on a data bus that has an output enable.

The clock-enable input `cke` is registered on every rising clock edge. A low value freezes the next internal cycle while a burst is running. On a frozen cycle, the command and write data are ignored, the burst position holds, and any read word being driven stays on the bus. When the engine is idle, `cke` has no effect.

The burst length and read latency are parameters. Activation, precharge, refresh, power-down and mode programming are handled elsewhere.

Top module: `sdb_burst_engine`

## Requirements
- R1: A WRITE (`cmd` = 2'b10) accepted while idle stores `dq_in` at column n on that same edge. The next three unsuspended edges store n+1, n+2 and n+3. Column order is sequential and wraps inside the aligned four-column group: the low two bits count modulo 4 and the upper bits stay fixed.
- R2: A READ (`cmd` = 2'b01) accepted while idle raises `dq_oe` and puts the word of column n on `dq_out` at the second unsuspended edge after the command. Each following unsuspended edge presents the next column in the same wrapped order.
- R3: `cke` acts one cycle early. A low value sampled at rising edge k suspends edge k+1 if a burst is active at that edge. This includes the read latency wait and the edge that ends a read.
- R4: On a suspended edge, the command and `dq_in` are ignored and nothing is stored.
- R5: On a suspended edge during a read, `dq_out` and `dq_oe` keep their values.
- R6: On a suspended edge, the burst position holds. After the suspend, the burst continues with the next column, and no column is skipped or repeated.
- R7: One unsuspended edge after the last read word, `dq_oe` returns low and the engine goes idle. A command given while a burst is active, and not suspended, is ignored.
- R8: While idle, a low `cke` has no effect. A command on the next edge is accepted normally.
- R9: An active-low `rst_n` clears `dq_oe` at once and returns the engine to idle. Command encoding 2'b00 and 2'b11 is a no-operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cke | input | 1 | Clock enable, registered each edge |
| cmd | input | 2 | 00 NOP, 01 READ, 10 WRITE, 11 NOP |
| bank | input | BANK_W (2) | Bank select, taken with the command |
| col | input | COL_W (4) | Starting column, taken with the command |
| dq_in | input | DATA_W (16) | Write data |
| dq_out | output | DATA_W (16) | Read data |
| dq_oe | output | 1 | High while read data is driven |

## Verification
A suspend often lands on the same edge as a burst step. The first case is a low `cke` during a write burst, where the frozen edge carries a stray READ and a decoy data word. The second is a low `cke` during read output, where the frozen edge carries a stray WRITE. Each frozen edge is judged by the value that later appears for the column concerned and by the bus holding its word for one extra cycle. Two more collisions are tested directly: a suspend inside the read latency wait, which must push the first word back by one cycle, and a suspend on the edge that would end a read, which must keep the last word driven for one more cycle.

// File: rtl/sdb_pkg.sv
package sdb_pkg;
  localparam logic [1:0] CMD_NOP   = 2'b00;
  localparam logic [1:0] CMD_READ  = 2'b01;
  localparam logic [1:0] CMD_WRITE = 2'b10;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'b00,
    ST_WR      = 2'b01,
    ST_RD_WAIT = 2'b10,
    ST_RD_OUT  = 2'b11
  } eng_state_e;
endpackage

// File: rtl/sdb_cke_gate.sv
module sdb_cke_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic cke,
  input  logic busy,
  output logic cke_q,
  output logic en
);
  // cke is registered every edge and steers the following internal edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cke_q <= 1'b1;
    else        cke_q <= cke;
  end

  // suspend only matters while a burst is running
  assign en = ~busy | cke_q;
endmodule

// File: rtl/sdb_col_seq.sv
module sdb_col_seq #(
  parameter int COL_W = 4,
  parameter int OFF_W = 2
) (
  input  logic [COL_W-1:0] base,
  input  logic [OFF_W-1:0] offset,
  output logic [COL_W-1:0] col_out
);
  logic [OFF_W-1:0] low_sum;

  assign low_sum = base[OFF_W-1:0] + offset;

  generate
    if (COL_W > OFF_W) begin : g_upper
      assign col_out = {base[COL_W-1:OFF_W], low_sum};
    end else begin : g_flat
      assign col_out = low_sum;
    end
  endgenerate
endmodule

// File: rtl/sdb_store.sv
module sdb_store #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
  end

  assign rdata = mem[addr];
endmodule

// File: rtl/sdb_burst_engine.sv
module sdb_burst_engine
  import sdb_pkg::*;
#(
  parameter int DATA_W    = 16,
  parameter int BANK_W    = 2,
  parameter int COL_W     = 4,
  parameter int BURST_LEN = 4,
  parameter int READ_LAT  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cke,
  input  logic [1:0]        cmd,
  input  logic [BANK_W-1:0] bank,
  input  logic [COL_W-1:0]  col,
  input  logic [DATA_W-1:0] dq_in,
  output logic [DATA_W-1:0] dq_out,
  output logic              dq_oe
);
  localparam int OFF_W  = $clog2(BURST_LEN);
  localparam int CNT_W  = $clog2(BURST_LEN + 1);
  localparam int WAIT_W = $clog2(READ_LAT) + 1;
  localparam int ADDR_W = BANK_W + COL_W;
  localparam logic [CNT_W-1:0]  BEAT_LAST = CNT_W'(BURST_LEN - 1);
  localparam logic [CNT_W-1:0]  BEAT_DONE = CNT_W'(BURST_LEN);
  localparam logic [WAIT_W-1:0] WAIT_INIT = WAIT_W'(READ_LAT - 1);

  eng_state_e        state_q, state_d;
  logic [CNT_W-1:0]  beat_q, beat_d;
  logic [WAIT_W-1:0] wait_q, wait_d;
  logic [BANK_W-1:0] bank_q, bank_d;
  logic [COL_W-1:0]  col_q, col_d;
  logic [DATA_W-1:0] dq_q, dq_d;
  logic              oe_q, oe_d;

  logic              busy, en, cke_q, we;
  logic [COL_W-1:0]  base_col, cur_col;
  logic [OFF_W-1:0]  offset;
  logic [BANK_W-1:0] cur_bank;
  logic [DATA_W-1:0] rdata;

  assign busy = (state_q != ST_IDLE);

  sdb_cke_gate u_gate (
    .clk   (clk),
    .rst_n (rst_n),
    .cke   (cke),
    .busy  (busy),
    .cke_q (cke_q),
    .en    (en)
  );

  // idle: address comes from the command; busy: from the latched base plus beat
  assign base_col = busy ? col_q : col;
  assign cur_bank = busy ? bank_q : bank;
  assign offset   = busy ? beat_q[OFF_W-1:0] : '0;

  sdb_col_seq #(.COL_W(COL_W), .OFF_W(OFF_W)) u_seq (
    .base    (base_col),
    .offset  (offset),
    .col_out (cur_col)
  );

  sdb_store #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_store (
    .clk   (clk),
    .we    (we),
    .addr  ({cur_bank, cur_col}),
    .wdata (dq_in),
    .rdata (rdata)
  );

  always_comb begin
    state_d = state_q;
    beat_d  = beat_q;
    wait_d  = wait_q;
    bank_d  = bank_q;
    col_d   = col_q;
    dq_d    = dq_q;
    oe_d    = oe_q;
    we      = 1'b0;
    if (en) begin
      unique case (state_q)
        ST_IDLE: begin
          if (cmd == CMD_WRITE) begin
            we      = 1'b1;
            bank_d  = bank;
            col_d   = col;
            beat_d  = CNT_W'(1);
            state_d = ST_WR;
          end else if (cmd == CMD_READ) begin
            bank_d  = bank;
            col_d   = col;
            beat_d  = '0;
            wait_d  = WAIT_INIT;
            state_d = ST_RD_WAIT;
          end
        end
        ST_WR: begin
          we = 1'b1;
          if (beat_q == BEAT_LAST) begin
            beat_d  = '0;
            state_d = ST_IDLE;
          end else begin
            beat_d = beat_q + CNT_W'(1);
          end
        end
        ST_RD_WAIT: begin
          if (wait_q == '0) begin
            dq_d    = rdata;
            oe_d    = 1'b1;
            beat_d  = CNT_W'(1);
            state_d = ST_RD_OUT;
          end else begin
            wait_d = wait_q - WAIT_W'(1);
          end
        end
        ST_RD_OUT: begin
          if (beat_q == BEAT_DONE) begin
            oe_d    = 1'b0;
            beat_d  = '0;
            state_d = ST_IDLE;
          end else begin
            dq_d   = rdata;
            beat_d = beat_q + CNT_W'(1);
          end
        end
        default: state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      beat_q  <= '0;
      wait_q  <= '0;
      bank_q  <= '0;
      col_q   <= '0;
      dq_q    <= '0;
      oe_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      beat_q  <= beat_d;
      wait_q  <= wait_d;
      bank_q  <= bank_d;
      col_q   <= col_d;
      dq_q    <= dq_d;
      oe_q    <= oe_d;
    end
  end

  assign dq_out = dq_q;
  assign dq_oe  = oe_q;

  // R5: a frozen edge leaves the bus exactly as it was
  a_r5_bus_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !cke_q) |=> ($stable(dq_out) && $stable(dq_oe)));

  // R6: the burst position does not move on a frozen edge
  a_r6_beat_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !cke_q) |=> $stable(beat_q));

  // R2: the bus only turns on out of the latency wait
  a_r2_oe_from_wait: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dq_oe) |-> ($past(state_q) == ST_RD_WAIT));

  // R7: the bus is driven only while read words are being shifted out
  a_r7_oe_in_output: assert property (@(posedge clk) disable iff (!rst_n)
    dq_oe |-> (state_q == ST_RD_OUT));

  // R8: a read arriving while idle is taken whatever cke did
  a_r8_idle_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE && cmd == CMD_READ) |=> (state_q == ST_RD_WAIT));
endmodule

// File: tb/tb_sdb_burst_engine.sv
module tb_sdb_burst_engine;
  localparam logic [1:0] NOP = 2'b00;
  localparam logic [1:0] RD  = 2'b01;
  localparam logic [1:0] WR  = 2'b10;

  logic        clk;
  logic        rst_n;
  logic        cke;
  logic [1:0]  cmd;
  logic [1:0]  bank;
  logic [3:0]  col;
  logic [15:0] dq_in;
  logic [15:0] dq_out;
  logic        dq_oe;

  int checks = 0;
  int fails  = 0;

  sdb_burst_engine dut (
    .clk(clk), .rst_n(rst_n), .cke(cke), .cmd(cmd), .bank(bank),
    .col(col), .dq_in(dq_in), .dq_out(dq_out), .dq_oe(dq_oe)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // vector: {req[45:42], cke[41], cmd[40:39], bank[38:37], col[36:33],
  //          din[32:17], exp_oe[16], exp_dq[15:0]}
  localparam int NV = 25;
  localparam logic [45:0] VEC [NV] = '{
    {4'd1, 1'b1, WR,  2'd1, 4'd5, 16'h1111, 1'b0, 16'h0000}, // R1 write base col 5
    {4'd7, 1'b1, RD,  2'd1, 4'd0, 16'h2222, 1'b0, 16'h0000}, // R7 stray read mid-burst
    {4'd3, 1'b0, NOP, 2'd0, 4'd0, 16'h3333, 1'b0, 16'h0000}, // R3 low cke, edge still runs
    {4'd4, 1'b1, RD,  2'd0, 4'd0, 16'h9999, 1'b0, 16'h0000}, // R4 frozen edge, decoy data
    {4'd6, 1'b1, NOP, 2'd0, 4'd0, 16'h4444, 1'b0, 16'h0000}, // R6 last write, wraps to 4
    {4'd2, 1'b1, RD,  2'd1, 4'd6, 16'h0000, 1'b0, 16'h0000}, // R2 read col 6
    {4'd2, 1'b1, NOP, 2'd0, 4'd0, 16'h0000, 1'b0, 16'h0000}, // R2 latency
    {4'd2, 1'b1, NOP, 2'd0, 4'd0, 16'h0000, 1'b1, 16'h2222}, // R2 first word
    {4'd6, 1'b0, NOP, 2'd0, 4'd0, 16'h0000, 1'b1, 16'h3333}, // R6 col 7
    {4'd5, 1'b1, WR,  2'd2, 4'd0, 16'hBEEF, 1'b1, 16'h3333}, // R5 frozen: held
    {4'd6, 1'b1, NOP, 2'd0, 4'd0, 16'h0000, 1'b1, 16'h4444}, // R6 col 4, no skip
    {4'd1, 1'b1, NOP, 2'd0, 4'd0, 16'h0000, 1'b1, 16'h1111}, // R1 col 5
    {4'd7, 1'b1, NOP, 2'd0, 4'd0, 16'h0000, 1'b0, 16'h0000}, // R7 bus released
    {4'd8, 1'b0, NOP, 2'd0, 4'd0, 16'h0000, 1'b0, 16'h0000}, // R8 idle low cke
    {4'd8, 1'b1, WR,  2'd2, 4'd0, 16'hAAAA, 1'b0, 16'h0000}, // R8 accepted anyway
    {4'd1, 1'b1, NOP, 2'd0, 4'd0, 16'hBBBB, 1'b0, 16'h0000}, // R1
    {4'd1, 1'b1, NOP, 2'd0, 4'd0, 16'hCCCC, 1'b0, 16'h0000}, // R1
    {4'd1, 1'b1, NOP, 2'd0, 4'd0, 16'hDDDD, 1'b0, 16'h0000}, // R1
    {4'd2, 1'b1, RD,  2'd2, 4'd3, 16'h0000, 1'b0, 16'h0000}, // R2 read col 3
    {4'd2, 1'b1, NOP, 2'd0, 4'd0, 16'h0000, 1'b0, 16'h0000}, // R2
    {4'd2, 1'b1, NOP, 2'd0, 4'd0, 16'h0000, 1'b1, 16'hDDDD}, // R2 col 3
    {4'd1, 1'b1, NOP, 2'd0, 4'd0, 16'h0000, 1'b1, 16'hAAAA}, // R1 wrap to col 0
    {4'd1, 1'b1, NOP, 2'd0, 4'd0, 16'h0000, 1'b1, 16'hBBBB}, // R1
    {4'd1, 1'b1, NOP, 2'd0, 4'd0, 16'h0000, 1'b1, 16'hCCCC}, // R1
    {4'd7, 1'b1, NOP, 2'd0, 4'd0, 16'h0000, 1'b0, 16'h0000}  // R7
  };

  task automatic tick(input logic k, input logic [1:0] c, input logic [1:0] b,
                      input logic [3:0] a, input logic [15:0] d);
    cke = k; cmd = c; bank = b; col = a; dq_in = d;
    @(negedge clk);
  endtask

  task automatic check(input int req, input logic eoe, input logic [15:0] edq);
    checks++;
    if (dq_oe !== eoe || (eoe && dq_out !== edq)) begin
      fails++;
      $display("FAIL R%0d: oe=%b dq=%h expected oe=%b dq=%h", req, dq_oe, dq_out, eoe, edq);
    end
  endtask

  initial begin
    #4_000_000;
    checks++; fails++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cke = 1'b1; cmd = NOP; bank = '0; col = '0; dq_in = '0;
    @(negedge clk); @(negedge clk);
    check(9, 1'b0, 16'h0); // R9 reset state
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      tick(VEC[i][41], VEC[i][40:39], VEC[i][38:37], VEC[i][36:33], VEC[i][32:17]);
      check(int'(VEC[i][45:42]), VEC[i][16], VEC[i][15:0]);
    end

    // R3: suspend inside the latency wait pushes the first word back one cycle
    tick(1'b1, RD, 2'd2, 4'd0, 16'h0);
    tick(1'b0, NOP, 2'd0, 4'd0, 16'h0);
    check(3, 1'b0, 16'h0);
    tick(1'b1, NOP, 2'd0, 4'd0, 16'h0);
    check(3, 1'b0, 16'h0);           // R3 frozen edge, still waiting
    tick(1'b1, NOP, 2'd0, 4'd0, 16'h0);
    check(3, 1'b1, 16'hAAAA);        // R3 first word one cycle later
    tick(1'b1, NOP, 2'd0, 4'd0, 16'h0);
    check(6, 1'b1, 16'hBBBB);        // R6
    tick(1'b1, NOP, 2'd0, 4'd0, 16'h0);
    check(6, 1'b1, 16'hCCCC);        // R6
    tick(1'b0, NOP, 2'd0, 4'd0, 16'h0);
    check(2, 1'b1, 16'hDDDD);        // R2 last word
    tick(1'b1, NOP, 2'd0, 4'd0, 16'h0);
    check(5, 1'b1, 16'hDDDD);        // R5 turn-off edge frozen, word held
    tick(1'b1, NOP, 2'd0, 4'd0, 16'h0);
    check(7, 1'b0, 16'h0);           // R7 released after the freeze

    // R9: asynchronous reset in the middle of read output
    tick(1'b1, RD, 2'd1, 4'd4, 16'h0);
    tick(1'b1, NOP, 2'd0, 4'd0, 16'h0);
    tick(1'b1, NOP, 2'd0, 4'd0, 16'h0);
    check(2, 1'b1, 16'h4444);        // R2
    #3 rst_n = 1'b0;
    #1 check(9, 1'b0, 16'h0);        // R9 immediate clear
    @(negedge clk);
    rst_n = 1'b1;
    tick(1'b1, NOP, 2'd0, 4'd0, 16'h0);
    check(9, 1'b0, 16'h0);           // R9 stays idle

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule